// File: doc/BRIEF.md
# Serial Memory Interface Front End with Pause

This block is the serial slave port of a byte-wide serial memory. A fast system clock samples the select, serial clock, data-in, pause (hold) and write-protect pins. Select, pause and write-protect are active low. All serial-clock edges are derived from those samples. The block takes a one-byte opcode, most significant bit first. It acts on three opcodes: read status, set write enable and write status. A read-status transfer drives the status byte on the serial output. High impedance is shown by an output-enable that is low.

The pause function can halt a transfer mid-stream while the part stays selected. A pause request, and its release, take effect only while the serial clock is low. A request made while the clock is high waits for the next low level. While paused, the bit count, the shift state and the decoded opcode are frozen. The serial clock and data-in are ignored, and the output is released. Any internal write that is already running continues: its busy flag comes from outside and is reported unchanged. Raising select at any time ends the instruction and cancels a pause.

Top module: `sermem_front`

## Requirements
- R1: Data-in is captured on each rising serial-clock edge while select is low, most significant bit first. The first eight bits form the opcode: 0x05 reads status, 0x06 sets write enable, 0x01 writes status. Any other opcode has no effect and drives no output.
- R2: After a read-status opcode, each falling serial-clock edge drives the next status bit, most significant bit first. The status byte is {disable bit, 3'b000, protect[1:0], write-enable, busy}, and it repeats for as long as clocking goes on.
- R3: The output-enable is low while the part is deselected, during the opcode, and for any opcode other than read status. It goes low again once select rises.
- R4: A pause request made while the serial clock is low starts the pause, and the output-enable drops.
- R5: A pause request made while the serial clock is high takes effect when the clock next falls. That falling edge still shifts the output one bit, and the output-enable stays high until then.
- R6: A release made while the clock is low ends the pause at once. A release made while the clock is high ends it at the next low level, and the falling edge at that moment is ignored.
- R7: During a pause, serial-clock and data-in activity has no effect. A transfer resumed after release completes as though it had not been paused, both in the opcode phase and in the output phase.
- R8: A pause request while deselected has no effect. Raising select during a pause cancels the pause and clears the bit count, so the next opcode decodes normally.
- R9: Opcode 0x06 sets the write-enable bit. The eighth data bit after opcode 0x01 loads bit 7 into the disable bit and bits 3:2 into protect[1:0], then clears write-enable. This happens only if write-enable was set; otherwise the write is refused.
- R10: A status write is refused while the disable bit is 1 and write-protect is low. With write-protect high it is accepted.
- R11: Status bit 0 follows the external busy input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select pin, active low |
| sck | input | 1 | Serial clock pin |
| sdi | input | 1 | Serial data-in pin |
| hold_n | input | 1 | Pause request pin, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| busy | input | 1 | Internal write-in-progress flag, synchronous to clk |
| sdo | output | 1 | Serial data-out value |
| sdo_oe | output | 1 | Output enable; low means high impedance |

## Verification
The assertions assume that every pin holds each level for several system clocks, longer than the synchronizer depth. Under that assumption, serial-clock levels and pause changes are seen in the same order in which the pins moved. The stimulus keeps each serial-clock half period at ten system clocks. Pause and select change only after the serial clock has settled for a full half period. The bench therefore never changes two pins within one synchronizer window. The busy input changes only while the part is deselected.

// File: rtl/sermem_front.sv
module sermem_front #(
  parameter int          SYNC    = 2,
  parameter logic [7:0]  OP_RDSR = 8'h05,
  parameter logic [7:0]  OP_WREN = 8'h06,
  parameter logic [7:0]  OP_WRSR = 8'h01
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  input  logic hold_n,
  input  logic wp_n,
  input  logic busy,
  output logic sdo,
  output logic sdo_oe
);

  localparam int TOP = SYNC - 1;

  logic [TOP:0] cs_p, sck_p, sdi_p, hold_p, wp_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p   <= '1;
      sck_p  <= '0;
      sdi_p  <= '0;
      hold_p <= '1;
      wp_p   <= '1;
    end else begin
      cs_p   <= {cs_p[TOP-1:0], cs_n};
      sck_p  <= {sck_p[TOP-1:0], sck};
      sdi_p  <= {sdi_p[TOP-1:0], sdi};
      hold_p <= {hold_p[TOP-1:0], hold_n};
      wp_p   <= {wp_p[TOP-1:0], wp_n};
    end
  end

  wire cs_s   = cs_p[TOP];
  wire sck_s  = sck_p[TOP];
  wire sdi_s  = sdi_p[TOP];
  wire hold_s = hold_p[TOP];
  wire wp_s   = wp_p[TOP];

  logic       sck_q, held, cmd_ok, drive, sdo_r, wel, srwd;
  logic [2:0] bit_cnt, oidx;
  logic [7:0] shreg, cmd;
  logic [1:0] bp;

  wire       active = ~cs_s & ~held;
  wire       tick_r = active & sck_s & ~sck_q;
  wire       tick_f = active & ~sck_s & sck_q;
  wire [7:0] nxt    = {shreg[6:0], sdi_s};
  wire [7:0] status = {srwd, 3'b000, bp, wel, busy};
  wire       wr_ok  = wel & ~(srwd & ~wp_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      held    <= 1'b0;
      cmd_ok  <= 1'b0;
      drive   <= 1'b0;
      sdo_r   <= 1'b0;
      wel     <= 1'b0;
      srwd    <= 1'b0;
      bp      <= 2'b00;
      bit_cnt <= 3'd0;
      oidx    <= 3'd7;
      shreg   <= 8'h00;
      cmd     <= 8'h00;
    end else begin
      sck_q <= sck_s;
      if (cs_s) begin
        held    <= 1'b0;
        cmd_ok  <= 1'b0;
        drive   <= 1'b0;
        bit_cnt <= 3'd0;
        oidx    <= 3'd7;
        shreg   <= 8'h00;
        cmd     <= 8'h00;
      end else begin
        if (!sck_s) held <= ~hold_s;
        if (tick_r) begin
          shreg   <= nxt;
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            if (!cmd_ok) begin
              cmd_ok <= 1'b1;
              cmd    <= nxt;
              if (nxt == OP_WREN) wel <= 1'b1;
            end else if (cmd == OP_WRSR && wr_ok) begin
              srwd <= nxt[7];
              bp   <= nxt[3:2];
              wel  <= 1'b0;
            end
          end
        end
        if (tick_f && cmd_ok && cmd == OP_RDSR) begin
          drive <= 1'b1;
          sdo_r <= status[oidx];
          oidx  <= oidx - 3'd1;
        end
      end
    end
  end

  assign sdo    = sdo_r;
  assign sdo_oe = drive & ~held & ~cs_s;

  assert_hold_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !cs_s) |=> ($stable(bit_cnt) && $stable(shreg) && $stable(oidx)));

  assert_hold_entry_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> $past(!sck_s));

  assert_hold_exit_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held) |-> ($past(!sck_s) || $past(cs_s)));

  assert_desel_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (bit_cnt == 3'd0 && !held && !sdo_oe));

  assert_protect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (srwd && !wp_s) |=> ($stable(srwd) && $stable(bp)));

endmodule

// File: tb/sermem_front_tb.sv
`timescale 1ns/1ps
module sermem_front_tb;
  localparam int H = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, hold_n = 1'b1, wp_n = 1'b1, busy = 1'b0;
  logic sdo, sdo_oe;
  int   n_chk = 0, n_fail = 0;
  logic done = 1'b0;
  logic oe_seen;

  always #2 clk = ~clk;

  sermem_front u_dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .hold_n(hold_n), .wp_n(wp_n), .busy(busy), .sdo(sdo), .sdo_oe(sdo_oe));

  task automatic waith(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b, output logic o);
    sdi = b;
    o = sdo;
    oe_seen = oe_seen | sdo_oe;
    sck = 1'b1; waith(H);
    sck = 1'b0; waith(H);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) clk_bit(tx[i], rx[i]);
  endtask

  task automatic sel();   cs_n = 1'b0; waith(H); endtask
  task automatic desel(); cs_n = 1'b1; waith(H); endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    sel(); xfer(op, r); desel();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    sel(); xfer(8'h01, r); xfer(v, r); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] r;
    sel(); xfer(8'h05, r); xfer(8'h00, s); desel();
  endtask

  task automatic t_reset();
    logic [7:0] s;
    chk("R3 reset oe", sdo_oe, 0);
    rdsr(s);
    chk("R2 reset status", s, 8'h00);
    chk("R3 oe after deselect", sdo_oe, 0);
  endtask

  task automatic t_repeat_busy();
    logic [7:0] r, a, b;
    busy = 1'b1;
    sel();
    oe_seen = 1'b0;
    xfer(8'h05, r);
    chk("R3 oe low during opcode", oe_seen, 0);
    xfer(8'h00, a); xfer(8'h00, b);
    desel();
    busy = 1'b0;
    chk("R11 busy bit", a, 8'h01);
    chk("R2 repeated byte", b, 8'h01);
  endtask

  task automatic t_unknown();
    logic [7:0] r, s;
    sel();
    oe_seen = 1'b0;
    xfer(8'hAB, r); xfer(8'h00, r);
    chk("R1 unknown opcode drives nothing", oe_seen, 0);
    desel();
    rdsr(s);
    chk("R1 unknown opcode no state change", s, 8'h00);
  endtask

  task automatic t_wren_wrsr();
    logic [7:0] s;
    cmd1(8'h06);
    rdsr(s); chk("R9 write enable set", s, 8'h02);
    wrsr(8'h0C);
    rdsr(s); chk("R9 status write accepted", s, 8'h0C);
    wrsr(8'h00);
    rdsr(s); chk("R9 write without enable refused", s, 8'h0C);
  endtask

  task automatic t_protect();
    logic [7:0] s;
    cmd1(8'h06); wrsr(8'h8C);
    rdsr(s); chk("R9 disable bit written", s, 8'h8C);
    wp_n = 1'b0; waith(H);
    cmd1(8'h06); wrsr(8'h00);
    rdsr(s); chk("R10 protected write refused", s, 8'h8E);
    wp_n = 1'b1; waith(H);
    wrsr(8'h0C);
    rdsr(s); chk("R10 write accepted with wp high", s, 8'h0C);
  endtask

  task automatic garbage();
    logic o;
    for (int i = 0; i < 3; i++) clk_bit(1'b1, o);
  endtask

  task automatic t_hold_low();
    logic [7:0] r, s;
    logic o;
    busy = 1'b1;
    sel(); xfer(8'h05, r);
    for (int i = 7; i >= 4; i--) clk_bit(1'b0, s[i]);
    hold_n = 1'b0; waith(2 * H);
    chk("R4 oe low in hold", sdo_oe, 0);
    oe_seen = 1'b0;
    garbage();
    chk("R7 no drive during hold", oe_seen, 0);
    hold_n = 1'b1; waith(H);
    chk("R6 oe back after release", sdo_oe, 1);
    for (int i = 3; i >= 0; i--) clk_bit(1'b0, s[i]);
    desel();
    busy = 1'b0;
    chk("R7 byte intact across hold", s, 8'h0D);
    sel();
    for (int i = 0; i < 4; i++) clk_bit((8'h06 >> (7 - i)) & 1, o);
    hold_n = 1'b0; waith(H);
    garbage();
    hold_n = 1'b1; waith(H);
    for (int i = 4; i < 8; i++) clk_bit((8'h06 >> (7 - i)) & 1, o);
    desel();
    rdsr(s);
    chk("R7 opcode intact across hold", s, 8'h0E);
  endtask

  task automatic t_hold_high();
    logic [7:0] r, s;
    sel(); xfer(8'h05, r);
    for (int i = 7; i >= 5; i--) clk_bit(1'b0, s[i]);
    s[4] = sdo;
    sck = 1'b1; waith(H);
    hold_n = 1'b0; waith(H);
    chk("R5 oe kept while clock high", sdo_oe, 1);
    sck = 1'b0; waith(H);
    chk("R5 hold starts at clock low", sdo_oe, 0);
    garbage();
    sck = 1'b1; waith(H);
    hold_n = 1'b1; waith(H);
    chk("R6 hold kept while clock high", sdo_oe, 0);
    sck = 1'b0; waith(H);
    chk("R6 hold ends at clock low", sdo_oe, 1);
    for (int i = 3; i >= 0; i--) clk_bit(1'b0, s[i]);
    desel();
    chk("R5 byte across delayed hold", s, 8'h0E);
  endtask

  task automatic t_hold_desel();
    logic [7:0] s;
    logic o;
    hold_n = 1'b0; waith(H); hold_n = 1'b1; waith(H);
    rdsr(s);
    chk("R8 hold while deselected ignored", s, 8'h0E);
    sel();
    for (int i = 0; i < 3; i++) clk_bit(1'b1, o);
    hold_n = 1'b0; waith(H);
    cs_n = 1'b1; waith(H);
    chk("R8 oe low after select rise", sdo_oe, 0);
    hold_n = 1'b1; waith(H);
    rdsr(s);
    chk("R8 counter cleared by select rise", s, 8'h0E);
  endtask

  initial begin
    waith(5);
    rst_n = 1'b1;
    waith(5);
    t_reset();
    t_repeat_busy();
    t_unknown();
    t_wren_wrsr();
    t_protect();
    t_hold_low();
    t_hold_high();
    t_hold_desel();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule